// File: doc/BRIEF.md
# Mesh Element Configuration Word Router

This block sits inside one element of a two-dimensional processing mesh and steers the words that arrive from its western and northern neighbours. Each link word carries a flag that marks it as configuration or as computational data. A configuration word also carries a relative destination (a horizontal and a vertical hop count) and an address in the element's microprogram store. The whole mesh is loaded through its upper-left element. Each element either keeps a configuration word or passes it one hop onward, so the same configuration stream works for a mesh of any size.

A configuration word whose two hop counts are both zero is written into the local microprogram store. In every other case it goes east or south, and the hop count for the direction taken drops by one. East is preferred. When east is occupied and the vertical count is non-zero, the word goes south instead. Computational data words are passed to the element's operator port. They are passed only while no configuration word is waiting in the element, so part of the mesh can be reconfigured while the rest keeps computing. Every link uses a valid/ready handshake. A word stays in its input slot until it is written locally or accepted by the next stage.

Top module: `cfgr_router`

## Requirements
- R1: After reset, the east, south and operator outputs are not valid, and both input ready signals are high.
- R2: A configuration word with both hop counts zero is written into the microprogram store at its store address and is never forwarded. Store data appears on the read data output one clock after the read address is presented.
- R3: A configuration word with a non-zero horizontal count and a zero vertical count leaves east with the horizontal count reduced by one. All other fields are unchanged.
- R4: A configuration word with a zero horizontal count and a non-zero vertical count leaves south with the vertical count reduced by one.
- R5: A configuration word with both counts non-zero leaves east, with the horizontal count reduced by one, when the east output is free.
- R6: A configuration word with both counts non-zero leaves south, with the vertical count reduced by one, while the east output holds a word that has not been accepted.
- R7: A configuration word that must go east waits in its input slot while east is occupied. During the wait that input's ready signal is low and nothing is emitted for that word. The word goes east once east frees.
- R8: A data word (flag bit 0) leaves on the operator port with its payload. It is never forwarded or written into the store, whatever its hop and address fields hold.
- R9: No data word is handed to the operator port while a configuration word is held in either input slot.
- R10: Every output that is valid and not accepted keeps its valid signal and its word unchanged in the next cycle.
- R11: A word accepted at one clock edge becomes valid on its output after the next edge. When both slots hold dispatchable configuration words, the west word goes before the north word.
- R12: Link word layout with default parameters, 30 bits, from the MSB down:
  - bit 29: configuration flag;
  - bits 28:25: horizontal count;
  - bits 24:21: vertical count;
  - bits 20:16: store address;
  - bits 15:0: payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| west_vld_i | input | 1 | West link word valid |
| west_rdy_o | output | 1 | West input slot empty |
| west_word_i | input | WORD_W | West link word |
| north_vld_i | input | 1 | North link word valid |
| north_rdy_o | output | 1 | North input slot empty |
| north_word_i | input | WORD_W | North link word |
| east_vld_o | output | 1 | East output valid |
| east_rdy_i | input | 1 | East neighbour accepts |
| east_word_o | output | WORD_W | Forwarded word, horizontal count reduced |
| south_vld_o | output | 1 | South output valid |
| south_rdy_i | input | 1 | South neighbour accepts |
| south_word_o | output | WORD_W | Forwarded word, vertical count reduced |
| op_vld_o | output | 1 | Operand valid toward operator |
| op_rdy_i | input | 1 | Operator ready for its next application |
| op_data_o | output | PAYLOAD_W | Operand payload |
| ucode_raddr_i | input | UADDR_W | Microprogram store read address |
| ucode_rdata_o | output | PAYLOAD_W | Microprogram store read data |

## Verification
A word accepted at one edge reaches an output register at the next edge. The bench therefore samples forwarded and operand outputs on falling edges. A direct check confirms the valid rise at the first falling edge after that second edge, not before. Store contents are read by presenting an address on a falling edge and sampling the next falling edge. For the stall and priority cases, the bench holds the east neighbour's ready low for several cycles. It confirms that nothing moves during the stall, and that the queued words drain in order within a fixed number of cycles after ready returns.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;
  typedef enum logic [1:0] {
    RT_WAIT  = 2'd0,
    RT_LOCAL = 2'd1,
    RT_EAST  = 2'd2,
    RT_SOUTH = 2'd3
  } route_e;
endpackage

// File: rtl/cfgr_in_slot.sv
module cfgr_in_slot #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_i,
  output logic         rdy_o,
  input  logic [W-1:0] word_i,
  input  logic         take_i,
  output logic         full_o,
  output logic [W-1:0] word_o
);
  logic         full_q;
  logic [W-1:0] word_q;

  assign rdy_o  = !full_q;
  assign full_o = full_q;
  assign word_o = word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else if (!full_q && vld_i) begin
      full_q <= 1'b1;
      word_q <= word_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  AST_SLOT_KEEP: assert property (@(posedge clk) disable iff (rst)
    full_q && !take_i |=> full_q && $stable(word_q)); // R7
  AST_TAKE_FULL: assert property (@(posedge clk) disable iff (rst)
    take_i |-> full_q); // R11
endmodule

// File: rtl/cfgr_route_dec.sv
module cfgr_route_dec
  import cfgr_pkg::*;
#(
  parameter int COORD_W = 4
) (
  input  logic [COORD_W-1:0] dx_i,
  input  logic [COORD_W-1:0] dy_i,
  input  logic               east_free_i,
  input  logic               south_free_i,
  output route_e             route_o
);
  logic dx_nz, dy_nz;
  assign dx_nz = |dx_i;
  assign dy_nz = |dy_i;

  always_comb begin
    route_o = RT_WAIT;
    if (!dx_nz && !dy_nz)
      route_o = RT_LOCAL;
    else if (dx_nz && east_free_i)
      route_o = RT_EAST;
    else if (dy_nz && south_free_i)
      route_o = RT_SOUTH;
  end
endmodule

// File: rtl/cfgr_out_reg.sv
module cfgr_out_reg #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  output logic         free_o,
  output logic         vld_o,
  input  logic         rdy_i,
  output logic [W-1:0] dout_o
);
  logic         vld_q;
  logic [W-1:0] data_q;

  assign free_o = !vld_q || rdy_i;
  assign vld_o  = vld_q;
  assign dout_o = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (load_i) begin
      vld_q  <= 1'b1;
      data_q <= din_i;
    end else if (rdy_i) begin
      vld_q <= 1'b0;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    vld_q && !rdy_i |=> vld_q && $stable(data_q)); // R10
endmodule

// File: rtl/cfgr_ucode_store.sv
module cfgr_ucode_store #(
  parameter int AW = 5,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/cfgr_router.sv
module cfgr_router
  import cfgr_pkg::*;
#(
  parameter int COORD_W   = 4,
  parameter int UADDR_W   = 5,
  parameter int PAYLOAD_W = 16,
  localparam int WORD_W   = 1 + 2*COORD_W + UADDR_W + PAYLOAD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 west_vld_i,
  output logic                 west_rdy_o,
  input  logic [WORD_W-1:0]    west_word_i,
  input  logic                 north_vld_i,
  output logic                 north_rdy_o,
  input  logic [WORD_W-1:0]    north_word_i,
  output logic                 east_vld_o,
  input  logic                 east_rdy_i,
  output logic [WORD_W-1:0]    east_word_o,
  output logic                 south_vld_o,
  input  logic                 south_rdy_i,
  output logic [WORD_W-1:0]    south_word_o,
  output logic                 op_vld_o,
  input  logic                 op_rdy_i,
  output logic [PAYLOAD_W-1:0] op_data_o,
  input  logic [UADDR_W-1:0]   ucode_raddr_i,
  output logic [PAYLOAD_W-1:0] ucode_rdata_o
);
  localparam int CFG_BIT = WORD_W - 1;
  localparam int DX_LSB  = CFG_BIT - COORD_W;
  localparam int DY_LSB  = DX_LSB - COORD_W;
  localparam int UA_LSB  = PAYLOAD_W;
  localparam int NPORT   = 2;

  logic [NPORT-1:0]  in_vld, in_rdy, full, take, is_cfg;
  logic [WORD_W-1:0] in_word   [NPORT];
  logic [WORD_W-1:0] slot_word [NPORT];
  route_e            rt        [NPORT];
  logic              east_free, south_free, op_free;

  assign in_vld     = {north_vld_i, west_vld_i};
  assign in_word[0] = west_word_i;
  assign in_word[1] = north_word_i;
  assign west_rdy_o  = in_rdy[0];
  assign north_rdy_o = in_rdy[1];

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    cfgr_in_slot #(.W(WORD_W)) u_slot (
      .clk(clk), .rst(rst),
      .vld_i(in_vld[g]), .rdy_o(in_rdy[g]), .word_i(in_word[g]),
      .take_i(take[g]), .full_o(full[g]), .word_o(slot_word[g])
    );
    assign is_cfg[g] = full[g] && slot_word[g][CFG_BIT];
    cfgr_route_dec #(.COORD_W(COORD_W)) u_dec (
      .dx_i(slot_word[g][DX_LSB +: COORD_W]),
      .dy_i(slot_word[g][DY_LSB +: COORD_W]),
      .east_free_i(east_free), .south_free_i(south_free),
      .route_o(rt[g])
    );
  end

  // Arbitration: configuration first (west over north), data only when
  // no configuration word is held anywhere in the element.
  logic        sel, grant_cfg, grant_data, any_cfg;
  route_e      sel_rt;
  logic [WORD_W-1:0] sel_word, east_din, south_din;
  logic        we, east_load, south_load, op_load;

  assign any_cfg = |is_cfg;

  always_comb begin
    sel        = 1'b0;
    grant_cfg  = 1'b0;
    grant_data = 1'b0;
    if (is_cfg[0] && rt[0] != RT_WAIT) begin
      grant_cfg = 1'b1;
    end else if (is_cfg[1] && rt[1] != RT_WAIT) begin
      sel = 1'b1; grant_cfg = 1'b1;
    end else if (!any_cfg && op_free) begin
      if (full[0]) begin
        grant_data = 1'b1;
      end else if (full[1]) begin
        sel = 1'b1; grant_data = 1'b1;
      end
    end
  end

  assign sel_rt   = rt[sel];
  assign sel_word = slot_word[sel];

  assign we         = grant_cfg && sel_rt == RT_LOCAL;
  assign east_load  = grant_cfg && sel_rt == RT_EAST;
  assign south_load = grant_cfg && sel_rt == RT_SOUTH;
  assign op_load    = grant_data;
  assign take[0]    = (grant_cfg || grant_data) && !sel;
  assign take[1]    = (grant_cfg || grant_data) && sel;

  always_comb begin
    east_din  = sel_word;
    south_din = sel_word;
    east_din[DX_LSB +: COORD_W]  = sel_word[DX_LSB +: COORD_W] - COORD_W'(1);
    south_din[DY_LSB +: COORD_W] = sel_word[DY_LSB +: COORD_W] - COORD_W'(1);
  end

  cfgr_out_reg #(.W(WORD_W)) u_east (
    .clk(clk), .rst(rst), .load_i(east_load), .din_i(east_din),
    .free_o(east_free), .vld_o(east_vld_o), .rdy_i(east_rdy_i),
    .dout_o(east_word_o)
  );

  cfgr_out_reg #(.W(WORD_W)) u_south (
    .clk(clk), .rst(rst), .load_i(south_load), .din_i(south_din),
    .free_o(south_free), .vld_o(south_vld_o), .rdy_i(south_rdy_i),
    .dout_o(south_word_o)
  );

  cfgr_out_reg #(.W(PAYLOAD_W)) u_op (
    .clk(clk), .rst(rst), .load_i(op_load), .din_i(sel_word[PAYLOAD_W-1:0]),
    .free_o(op_free), .vld_o(op_vld_o), .rdy_i(op_rdy_i),
    .dout_o(op_data_o)
  );

  cfgr_ucode_store #(.AW(UADDR_W), .DW(PAYLOAD_W)) u_store (
    .clk(clk), .we_i(we),
    .waddr_i(sel_word[UA_LSB +: UADDR_W]),
    .wdata_i(sel_word[PAYLOAD_W-1:0]),
    .raddr_i(ucode_raddr_i), .rdata_o(ucode_rdata_o)
  );

  AST_ONE_SINK: assert property (@(posedge clk) disable iff (rst)
    $countones({we, east_load, south_load, op_load}) <= 1); // R2
  AST_DATA_PRIO: assert property (@(posedge clk) disable iff (rst)
    op_load |-> !(full[0] && slot_word[0][CFG_BIT]) && !(full[1] && slot_word[1][CFG_BIT])); // R9
  AST_DATA_NOT_STORED: assert property (@(posedge clk) disable iff (rst)
    we |-> sel_word[CFG_BIT]); // R8
  AST_EAST_NEEDS_DX: assert property (@(posedge clk) disable iff (rst)
    east_load |-> |sel_word[DX_LSB +: COORD_W]); // R3
  AST_SOUTH_NEEDS_DY: assert property (@(posedge clk) disable iff (rst)
    south_load |-> |sel_word[DY_LSB +: COORD_W]); // R4
endmodule

// File: tb/cfgr_router_bench.sv
module cfgr_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4, UW = 5, PW = 16;
  localparam int WW = 1 + 2*CW + UW + PW;

  logic clk = 1'b0, rst = 1'b1;
  logic west_vld = 0, north_vld = 0, west_rdy, north_rdy;
  logic [WW-1:0] west_word = '0, north_word = '0, east_word, south_word;
  logic east_vld, south_vld, op_vld;
  logic east_rdy = 1, south_rdy = 1, op_rdy = 1;
  logic [PW-1:0] op_data, rdata;
  logic [UW-1:0] raddr = '0;

  int checks = 0, errors = 0;
  int east_cnt = 0, south_cnt = 0, op_cnt = 0;
  logic [WW-1:0] east_last = '0, east_prev = '0, south_last = '0;
  logic [PW-1:0] op_last = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgr_router #(.COORD_W(CW), .UADDR_W(UW), .PAYLOAD_W(PW)) u_cfgr_router (
    .clk(clk), .rst(rst),
    .west_vld_i(west_vld), .west_rdy_o(west_rdy), .west_word_i(west_word),
    .north_vld_i(north_vld), .north_rdy_o(north_rdy), .north_word_i(north_word),
    .east_vld_o(east_vld), .east_rdy_i(east_rdy), .east_word_o(east_word),
    .south_vld_o(south_vld), .south_rdy_i(south_rdy), .south_word_o(south_word),
    .op_vld_o(op_vld), .op_rdy_i(op_rdy), .op_data_o(op_data),
    .ucode_raddr_i(raddr), .ucode_rdata_o(rdata)
  );

  always @(posedge clk) if (!rst) begin
    if (east_vld && east_rdy) begin
      east_cnt <= east_cnt + 1; east_prev <= east_last; east_last <= east_word;
    end
    if (south_vld && south_rdy) begin
      south_cnt <= south_cnt + 1; south_last <= south_word;
    end
    if (op_vld && op_rdy) begin
      op_cnt <= op_cnt + 1; op_last <= op_data;
    end
  end

  function automatic logic [WW-1:0] mk(logic c, logic [CW-1:0] dx, logic [CW-1:0] dy,
                                       logic [UW-1:0] ua, logic [PW-1:0] pl);
    return {c, dx, dy, ua, pl};
  endfunction

  // expected sink with both outputs free: 0 store, 1 east, 2 south, 3 operator
  function automatic int exp_sink(logic [WW-1:0] w);
    if (!w[WW-1]) return 3;
    if (w[WW-2 -: CW] == 0 && w[WW-2-CW -: CW] == 0) return 0;
    if (w[WW-2 -: CW] != 0) return 1;
    return 2;
  endfunction

  function automatic logic [WW-1:0] dec_x(logic [WW-1:0] w);
    logic [WW-1:0] r = w;
    r[WW-2 -: CW] = w[WW-2 -: CW] - 1'b1;
    return r;
  endfunction

  function automatic logic [WW-1:0] dec_y(logic [WW-1:0] w);
    logic [WW-1:0] r = w;
    r[WW-2-CW -: CW] = w[WW-2-CW -: CW] - 1'b1;
    return r;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(int p, logic [WW-1:0] w);
    @(negedge clk);
    if (p == 0) begin west_word = w; west_vld = 1; while (!west_rdy) @(negedge clk); end
    else begin north_word = w; north_vld = 1; while (!north_rdy) @(negedge clk); end
    @(negedge clk);
    west_vld = 0; north_vld = 0;
  endtask

  task automatic send2(logic [WW-1:0] ww, logic [WW-1:0] nw);
    @(negedge clk);
    west_word = ww; north_word = nw; west_vld = 1; north_vld = 1;
    @(negedge clk);
    west_vld = 0; north_vld = 0;
  endtask

  task automatic rd(logic [UW-1:0] a, output logic [PW-1:0] d);
    @(negedge clk); raddr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [PW-1:0] d;
    logic [WW-1:0] w, a, b, c;
    int e0, s0, o0;
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "east_vld", east_vld, 0);
    chk("R1", "south_vld", south_vld, 0);
    chk("R1", "op_vld", op_vld, 0);
    chk("R1", "rdys", {west_rdy, north_rdy}, 2'b11);

    // R11 latency: accept edge, then valid after next edge
    @(negedge clk);
    west_word = mk(1, 1, 0, 3, 16'h1234); west_vld = 1;
    @(negedge clk); west_vld = 0;
    chk("R11", "east not yet valid", east_vld, 0);
    @(negedge clk);
    chk("R11", "east valid", east_vld, 1);
    chk("R3", "east word", east_word, mk(1, 0, 0, 3, 16'h1234));
    repeat (2) @(negedge clk);

    // R11 west before north
    a = mk(1, 2, 0, 1, 16'haaaa); b = mk(1, 3, 0, 2, 16'hbbbb);
    send2(b, a);
    repeat (4) @(negedge clk);
    chk("R11", "first east (west)", east_prev, dec_x(b));
    chk("R11", "second east (north)", east_last, dec_x(a));

    // R6 / R7 east busy
    east_rdy = 0;
    e0 = east_cnt; s0 = south_cnt;
    a = mk(1, 1, 0, 4, 16'h0a0a);
    send(0, a);
    repeat (2) @(negedge clk);
    b = mk(1, 2, 3, 5, 16'h0b0b);
    send(1, b);
    repeat (3) @(negedge clk);
    chk("R6", "south count", south_cnt - s0, 1);
    chk("R6", "south word", south_last, dec_y(b));
    c = mk(1, 1, 0, 6, 16'h0c0c);
    send(0, c);
    repeat (3) @(negedge clk);
    chk("R7", "west rdy low while waiting", west_rdy, 0);
    chk("R7", "east holds first", east_word, dec_x(a));
    chk("R7", "no south", south_cnt - s0, 1);
    chk("R10", "east valid held", east_vld, 1);
    east_rdy = 1;
    repeat (4) @(negedge clk);
    chk("R7", "east count after release", east_cnt - e0, 2);
    chk("R7", "east last", east_last, dec_x(c));

    // R9 priority: data waits while config held
    east_rdy = 0;
    send(0, mk(1, 1, 0, 0, 16'h0d0d));
    repeat (2) @(negedge clk);
    o0 = op_cnt;
    a = mk(0, 0, 0, 7, 16'h5a5a);
    b = mk(1, 1, 0, 8, 16'h0e0e);
    send2(a, b);
    repeat (4) @(negedge clk);
    chk("R9", "op held while config waits", op_cnt - o0, 0);
    chk("R9", "op_vld low", op_vld, 0);
    east_rdy = 1;
    repeat (5) @(negedge clk);
    chk("R9", "op after config", op_cnt - o0, 1);
    chk("R9", "op payload", op_last, 16'h5a5a);
    chk("R9", "config went first", east_last, dec_x(b));

    // R8 data with zero hops does not touch store
    send(0, mk(1, 0, 0, 9, 16'h7777));
    repeat (2) @(negedge clk);
    e0 = east_cnt; s0 = south_cnt; o0 = op_cnt;
    send(1, mk(0, 0, 0, 9, 16'h1111));
    repeat (3) @(negedge clk);
    rd(9, d);
    chk("R8", "store unchanged", d, 16'h7777);
    chk("R8", "op payload", op_last, 16'h1111);
    chk("R8", "no forward", (east_cnt - e0) + (south_cnt - s0), 0);

    // random traffic, all outputs free
    for (int i = 0; i < 60; i++) begin
      int p, k;
      w = mk(($urandom_range(0, 4) != 0), CW'($urandom_range(0, 3)), CW'($urandom_range(0, 3)),
             UW'($urandom), PW'($urandom));
      if (i < 4) w = mk(1, 0, 0, UW'(i + 20), PW'(16'hc000 + i)); // directed local writes
      p = $urandom_range(0, 1);
      e0 = east_cnt; s0 = south_cnt; o0 = op_cnt;
      send(p, w);
      repeat (3) @(negedge clk);
      k = exp_sink(w);
      case (k)
        0: begin
          rd(w[PW +: UW], d);
          chk("R2", "store data", d, w[PW-1:0]);
          chk("R2", "no forward", (east_cnt - e0) + (south_cnt - s0) + (op_cnt - o0), 0);
        end
        1: begin
          chk(w[WW-2-CW -: CW] != 0 ? "R5" : "R3", "east word", east_last, dec_x(w));
          chk("R3", "east count", east_cnt - e0, 1);
        end
        2: begin
          chk("R4", "south word", south_last, dec_y(w));
          chk("R4", "south count", south_cnt - s0, 1);
        end
        default: begin
          chk("R8", "op payload", op_last, w[PW-1:0]);
          chk("R8", "op count", (op_cnt - o0) + (east_cnt - e0) + (south_cnt - s0), 1);
        end
      endcase
    end
    chk("R12", "word width", WW, 30);
    finish_run();
  end
endmodule